// File: doc/BRIEF.md
# Wake-Up Frame Pattern Filter

This block sits beside an Ethernet receive path. It watches each incoming frame byte by byte and compares it against seven stored wake-up patterns. Each pattern has its own per-byte compare mask and its own match length. When an enabled pattern is satisfied, the block sets a latched per-pattern status bit and a wake event flag. The flag, gated by an enable bit, drives a wake interrupt.

Software reaches the pattern store indirectly. It first places a 9-bit entry in a write-data register. It then writes a command word that selects the pattern and the byte index, and sets either a commit strobe or a read-back strobe. Match lengths, pattern enables, status, the interrupt flag and the interrupt enable are plain registers on the same word-addressed register port. Reads take effect in the cycle in which `reg_rd` is high.

Register map (word addresses on `reg_addr`):

| Address | Register |
|---|---|
| 0 | Control |
| 1 | Status |
| 2 | Length of pattern 0 |
| 3 | Lengths of patterns 1 and 2 |
| 4 | Lengths of patterns 3 and 4 |
| 5 | Lengths of patterns 5 and 6 |
| 6 | Command |
| 7 | Write data |
| 8 | Read data |
| 9 | Interrupt status |
| 10 | Interrupt enable |

Top module: `wol_pattern_filter`

## Requirements
- R1: A write to the command register (address 6) acts on the entry whose pattern number is in bits 9:7 and whose byte index is in bits 6:0. Bit 10 set copies the write-data register (address 7, bits 8:0) into that entry. Bit 11 set loads that entry into the read-data register (address 8), which appears at bits 8:0 one cycle later. In both registers bit 8 is the compare-enable bit and bits 7:0 are the byte value.
- R2: A command that names pattern number 7 neither writes nor reads any entry, and it leaves the read-data register unchanged.
- R3: Frame byte k, counted from 0 at the first byte after the start-of-frame pulse, is compared with entry k of every pattern. An entry with bit 8 clear accepts any byte. An entry with bit 8 set rejects any byte other than its bits 7:0, and the pattern then fails for the rest of the frame.
- R4: A pattern matches at the byte with index equal to its length field, provided that no byte up to that index has mismatched. A frame that ends before that byte gives no match.
- R5: The length field holds the number of compared bytes minus one. Pattern 0 uses bits 6:0 of address 2. Patterns 1/2, 3/4 and 5/6 use addresses 3, 4 and 5, with the odd pattern in bits 6:0 and the even pattern in bits 13:7. These registers read back as written.
- R6: Bits 6:0 of the control register (address 0) enable patterns 0 to 6. A disabled pattern never sets its status bit.
- R7: All enabled patterns are evaluated in parallel on the same frame. Status register bit p (address 1) is set when pattern p matches.
- R8: Status bits and the wake flag stay set until the status register is read. The read returns the value held before the clear, and it clears every status bit and the wake flag. A match in the same cycle as that read leaves its bit and the wake flag set.
- R9: The wake flag appears at bit 7 of address 9, and the wake enable sits at bit 7 of address 10. `wake_irq` is high exactly when both are set.
- R10: A start-of-frame pulse restarts byte counting and clears every mismatch. Bytes that arrive after an end-of-frame pulse and before the next start-of-frame pulse are ignored.
- R11: After reset every register reads zero and `wake_irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sof | input | 1 | Start-of-frame pulse; carries no byte |
| rx_valid | input | 1 | `rx_data` holds a frame byte |
| rx_data | input | 8 | Frame byte |
| rx_eof | input | 1 | End-of-frame pulse; carries no byte |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (status read clears) |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr`, valid in the same cycle |
| wake_irq | output | 1 | Wake interrupt |

## Verification
The store geometry is fixed by the command-word layout: seven patterns of 128 entries. The bench therefore builds the block with no parameter overrides and covers the whole geometry. It reaches the last byte index and the unused pattern code 7. It uses patterns of different lengths in both halves of the shared length registers. It also lines up a status read with a match in the same cycle.

// File: rtl/wol_pattern_filter.sv
module wol_pattern_filter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_sof,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_eof,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [3:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        wake_irq
);
  localparam int NPAT  = 7;
  localparam int DEPTH = 128;
  localparam int IW    = $clog2(DEPTH);
  localparam int PW    = $clog2(NPAT + 1);

  localparam logic [3:0] A_CTRL = 4'd0, A_STAT = 4'd1, A_LEN0 = 4'd2, A_LEN12 = 4'd3,
                         A_LEN34 = 4'd4, A_LEN56 = 4'd5, A_CMD = 4'd6, A_WDAT = 4'd7,
                         A_RDAT = 4'd8, A_ISTAT = 4'd9, A_IEN = 4'd10;

  logic [8:0]      mem [0:NPAT*DEPTH-1];
  logic [8:0]      wd_q, rd_q;
  logic [NPAT-1:0] en_q, stat_q, fail_q, mism, hit;
  logic [IW-1:0]   l0_q;
  logic [2*IW-1:0] l12_q, l34_q, l56_q;
  logic [IW-1:0]   len [NPAT];
  logic [IW:0]     cnt_q;
  logic            act_q, wake_q, ie_q;
  logic [PW-1:0]   cmd_pat;
  logic [IW-1:0]   cmd_idx;
  logic            cmd_ok, byte_ok, clr;
  logic            unused_bits;

  assign len[0] = l0_q;
  assign len[1] = l12_q[IW-1:0];
  assign len[2] = l12_q[2*IW-1:IW];
  assign len[3] = l34_q[IW-1:0];
  assign len[4] = l34_q[2*IW-1:IW];
  assign len[5] = l56_q[IW-1:0];
  assign len[6] = l56_q[2*IW-1:IW];

  assign cmd_idx  = reg_wdata[IW-1:0];
  assign cmd_pat  = reg_wdata[IW+PW-1:IW];
  assign cmd_ok   = reg_wr && reg_addr == A_CMD && cmd_pat != PW'(NPAT);
  assign byte_ok  = act_q && rx_valid && !rx_sof && !rx_eof && !cnt_q[IW];
  assign clr      = reg_rd && reg_addr == A_STAT;
  assign wake_irq = wake_q && ie_q;
  assign unused_bits = ^reg_wdata[15:14];

  for (genvar p = 0; p < NPAT; p++) begin : g_cmp
    logic [8:0] ent;
    assign ent     = mem[{PW'(p), cnt_q[IW-1:0]}];
    assign mism[p] = ent[8] && ent[7:0] != rx_data;
    assign hit[p]  = byte_ok && en_q[p] && !fail_q[p] && !mism[p] && cnt_q[IW-1:0] == len[p];
  end

  always_ff @(posedge clk)
    if (cmd_ok && reg_wdata[10]) mem[{cmd_pat, cmd_idx}] <= wd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0; stat_q <= '0; fail_q <= '0;
      l0_q <= '0; l12_q <= '0; l34_q <= '0; l56_q <= '0;
      wd_q <= '0; rd_q <= '0; cnt_q <= '0;
      act_q <= 1'b0; wake_q <= 1'b0; ie_q <= 1'b0;
    end else begin
      if (reg_wr)
        case (reg_addr)
          A_CTRL:  en_q  <= reg_wdata[NPAT-1:0];
          A_LEN0:  l0_q  <= reg_wdata[IW-1:0];
          A_LEN12: l12_q <= reg_wdata[2*IW-1:0];
          A_LEN34: l34_q <= reg_wdata[2*IW-1:0];
          A_LEN56: l56_q <= reg_wdata[2*IW-1:0];
          A_WDAT:  wd_q  <= reg_wdata[8:0];
          A_IEN:   ie_q  <= reg_wdata[7];
          default: ;
        endcase
      if (cmd_ok && reg_wdata[11]) rd_q <= mem[{cmd_pat, cmd_idx}];

      if (rx_sof) begin
        act_q <= 1'b1; cnt_q <= '0; fail_q <= '0;
      end else if (rx_eof) begin
        act_q <= 1'b0;
      end else if (byte_ok) begin
        cnt_q  <= cnt_q + 1'b1;
        fail_q <= fail_q | mism;
      end

      stat_q <= (clr ? '0 : stat_q) | hit;
      wake_q <= (wake_q && !clr) || (|hit);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = 16'(en_q);
      A_STAT:  reg_rdata = 16'(stat_q);
      A_LEN0:  reg_rdata = 16'(l0_q);
      A_LEN12: reg_rdata = 16'(l12_q);
      A_LEN34: reg_rdata = 16'(l34_q);
      A_LEN56: reg_rdata = 16'(l56_q);
      A_WDAT:  reg_rdata = 16'(wd_q);
      A_RDAT:  reg_rdata = 16'(rd_q);
      A_ISTAT: reg_rdata = {8'd0, wake_q, 7'd0};
      A_IEN:   reg_rdata = {8'd0, ie_q, 7'd0};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wol_filter_checks.sv
module wol_filter_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_rd,
  input logic [3:0] reg_addr,
  input logic       rx_sof,
  input logic [6:0] en_q,
  input logic [6:0] stat_q,
  input logic       wake_q,
  input logic       wake_irq
);
  assert_sticky_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_addr == 4'd1) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_flag_follows_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q != 7'd0) |-> wake_q);

  assert_irq_needs_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> (stat_q != 7'd0));

  assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat_q & ~$past(stat_q) & ~$past(en_q)) == 7'd0));

  assert_sof_no_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sof |=> ((stat_q & ~$past(stat_q)) == 7'd0));
endmodule

bind wol_pattern_filter wol_filter_checks u_checks (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr), .rx_sof(rx_sof),
  .en_q(en_q), .stat_q(stat_q), .wake_q(wake_q), .wake_irq(wake_irq)
);

// File: tb/tb_wol_pattern_filter.sv
module tb_wol_pattern_filter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_sof = 0, rx_valid = 0, rx_eof = 0, reg_wr = 0, reg_rd = 0;
  logic [7:0] rx_data = '0;
  logic [3:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata, rdv, cap;
  logic wake_irq;

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] fq[$];

  // behavioural reference state
  int mmem[896];
  int mlen[7];
  int men, mstat, mwake, mie, mwd, mcnt, mact;
  bit mfail[7];

  wol_pattern_filter dut (.*);

  always #5 clk = ~clk;

  task automatic chk(string tag, int got, int exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    int hits, e, k;
    bit mis;
    if (!rst_n) begin
      men = 0; mstat = 0; mwake = 0; mie = 0; mwd = 0; mcnt = 0; mact = 0;
      foreach (mlen[i]) mlen[i] = 0;
      foreach (mfail[i]) mfail[i] = 0;
    end else begin
      hits = 0;
      if (rx_sof) begin
        mact = 1; mcnt = 0;
        foreach (mfail[i]) mfail[i] = 0;
      end else if (rx_eof) mact = 0;
      else if (mact != 0 && rx_valid && mcnt < 128) begin
        for (int p = 0; p < 7; p++) begin
          e = mmem[p*128 + mcnt];
          mis = (e >= 256) && ((e % 256) != int'(rx_data));
          if (!mis && !mfail[p] && ((men >> p) & 1) == 1 && mcnt == mlen[p]) hits |= (1 << p);
          if (mis) mfail[p] = 1;
        end
        mcnt++;
      end
      if (reg_rd && reg_addr == 4'd1) begin mstat = 0; mwake = 0; end
      mstat |= hits;
      if (hits != 0) mwake = 1;
      if (reg_wr) begin
        case (reg_addr)
          4'd0: men = reg_wdata & 16'h7F;
          4'd2: mlen[0] = reg_wdata & 16'h7F;
          4'd3, 4'd4, 4'd5: begin
            k = (int'(reg_addr) - 3) * 2 + 1;
            mlen[k] = reg_wdata & 16'h7F;
            mlen[k+1] = (reg_wdata >> 7) & 16'h7F;
          end
          4'd6: if (reg_wdata[10] && reg_wdata[9:7] != 3'd7) mmem[reg_wdata & 16'h3FF] = mwd;
          4'd7: mwd = reg_wdata & 16'h1FF;
          4'd10: mie = reg_wdata[7];
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk)
    if (rst_n && !finished) chk("R9 irq per cycle", wake_irq, (mwake != 0 && mie != 0) ? 1 : 0);

  task automatic reg_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [15:0] v);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #2 v = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic put(input int pat, input int idx, input int val);
    reg_write(4'd7, 16'(val));
    reg_write(4'd6, 16'(32'h400 | (pat << 7) | idx));
  endtask

  task automatic send(input int rd_at, input bit use_sof, input bit use_eof);
    @(negedge clk);
    if (use_sof) begin rx_sof = 1; @(negedge clk); rx_sof = 0; end
    foreach (fq[i]) begin
      rx_valid = 1; rx_data = fq[i];
      if (i == rd_at) begin reg_rd = 1; reg_addr = 4'd1; #2 cap = reg_rdata; end
      @(negedge clk);
      reg_rd = 0;
    end
    rx_valid = 0;
    if (use_eof) begin rx_eof = 1; @(negedge clk); rx_eof = 0; end
  endtask

  task automatic expect_stat(string tag, int exp);
    reg_read(4'd1, rdv); chk(tag, rdv, exp);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    foreach (mmem[i]) mmem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    chk("R11 irq after reset", wake_irq, 0);
    reg_read(4'd0, rdv); chk("R11 control", rdv, 0);
    reg_read(4'd1, rdv); chk("R11 status", rdv, 0);
    reg_read(4'd9, rdv); chk("R11 int status", rdv, 0);
    reg_read(4'd3, rdv); chk("R11 length", rdv, 0);

    for (int i = 0; i < 896; i++) put(i / 128, i % 128, 0);

    for (int i = 0; i < 6; i++) put(0, i, 9'h1FF);
    put(1, 0, 9'h1AA); put(1, 1, 9'h1BB); put(1, 2, 9'h055); put(1, 3, 9'h1CC);
    for (int i = 0; i < 10; i++) put(2, i, 9'h110 + i);
    put(6, 0, 9'h1AA);
    reg_write(4'd2, 16'd5);
    reg_write(4'd3, 16'h0483);
    reg_write(4'd5, 16'h0080);
    reg_read(4'd3, rdv); chk("R5 len 1/2 packing", rdv, 16'h0483);
    reg_read(4'd5, rdv); chk("R5 len 5/6 packing", rdv, 16'h0080);
    reg_write(4'd0, 16'h0047);
    reg_read(4'd0, rdv); chk("R6 control readback", rdv, 16'h0047);

    // R1 indirect access
    put(3, 100, 9'h1A5);
    reg_write(4'd6, 16'h09E4);
    reg_read(4'd8, rdv); chk("R1 readback p3 i100", rdv, 16'h01A5);
    put(5, 127, 9'h1EE);
    reg_write(4'd6, 16'h0800 | (5 << 7) | 127);
    reg_read(4'd8, rdv); chk("R1 readback last index", rdv, 16'h01EE);
    reg_write(4'd6, 16'h0801);
    reg_read(4'd8, rdv); chk("R1 readback p0 i1", rdv, 16'h01FF);
    // R2 pattern code 7
    reg_write(4'd7, 16'h0123);
    reg_write(4'd6, 16'h0785);
    reg_write(4'd6, 16'h0B85);
    reg_read(4'd8, rdv); chk("R2 code 7 keeps rdata", rdv, 16'h01FF);
    reg_write(4'd6, 16'h0B05);
    reg_read(4'd8, rdv); chk("R2 p6 i5 untouched", rdv, 16'h0000);

    // R9 gating, R8 clear
    fq = {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h12, 8'h34};
    send(-1, 1, 1);
    reg_read(4'd9, rdv); chk("R9 wake flag bit7", rdv, 16'h0080);
    chk("R9 irq masked", wake_irq, 0);
    reg_write(4'd10, 16'h0080);
    chk("R9 irq enabled", wake_irq, 1);
    reg_read(4'd10, rdv); chk("R9 enable readback", rdv, 16'h0080);
    expect_stat("R8 status read", 16'h0001);
    chk("R8 irq after clear", wake_irq, 0);
    expect_stat("R8 status cleared", 0);
    reg_read(4'd9, rdv); chk("R8 flag cleared", rdv, 0);

    // R7 parallel + R3 don't-care
    fq = {8'hAA, 8'hBB, 8'h77, 8'hCC};
    send(-1, 1, 1);
    expect_stat("R7 parallel p1 p6", 16'h0042);
    fq = {8'hAA, 8'hBB, 8'h77};
    send(-1, 1, 1);
    expect_stat("R4 short frame", 16'h0040);
    fq = {8'hAA, 8'hBC, 8'h77, 8'hCC};
    send(-1, 1, 1);
    expect_stat("R3 mismatch fails p1", 16'h0040);

    // R5 even half length
    fq = {};
    for (int i = 0; i < 10; i++) fq.push_back(8'(8'h10 + i));
    send(-1, 1, 1);
    expect_stat("R5 p2 length 10", 16'h0004);
    void'(fq.pop_back());
    send(-1, 1, 1);
    expect_stat("R4 p2 one byte short", 0);

    // R6 disable
    reg_write(4'd0, 16'h0046);
    fq = {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    send(-1, 1, 1);
    expect_stat("R6 disabled p0", 0);
    reg_write(4'd0, 16'h0047);

    // R10 frame boundaries
    fq = {8'hFF, 8'hFF, 8'h00};
    send(-1, 1, 0);
    fq = {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    send(-1, 1, 1);
    expect_stat("R10 sof clears mismatch", 16'h0001);
    send(-1, 0, 0);
    expect_stat("R10 bytes outside frame", 0);
    fq = {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    send(-1, 1, 1);
    expect_stat("R4 five of six bytes", 0);

    // R8 same-cycle clear and match
    fq = {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    send(-1, 1, 1);
    fq = {8'hAA, 8'hBB, 8'h77, 8'hCC};
    send(3, 1, 1);
    chk("R8 read value before clear", cap, 16'h0041);
    expect_stat("R8 match wins over clear", 16'h0002);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule